// File: doc/BRIEF.md
# MIDI Host Bus Port

This block lets a microprocessor exchange MIDI bytes with a synthesizer subsystem over an 8-bit asynchronous bus. The bus has an active-low chip select, active-low read and write strobes, and a single register-select bit. With the select bit low, the host reaches the byte data register. With it high, a read returns a status byte and a write is taken as a port command. A byte is transferred when the strobe goes high again, in both directions. The strobes, the select bit and the write data are brought into the system clock through two-flop synchronizers before any edge is detected.

A serial MIDI receiver (8N1, least significant bit first, mid-bit sampling) watches the MIDI input line. After reset, each received byte is handed to the synthesizer. A pass-through command sends received bytes into a one-byte holding register instead, and the host reads them from there. An interrupt line is high while that register holds a byte. Host data writes always go to a synthesizer-side byte output. Each command the port recognises queues an acknowledge byte for the host.

Top module: `midi_host_port`

## Requirements
- R1: After reset: received bytes are routed to the synthesizer, `irq` is low, `rx_overrun` is low, `passthru` is low, and a status read returns 0xBF.
- R2: With `addr`=0, `host_dout` shows the holding register. With `addr`=1, it shows status: bit 7 is 0 when a byte is held, bit 6 is 1 while data writes are blocked, and bits 5..0 are always 1.
- R3: A data write (`addr`=0) takes effect on the rising edge of `wr_n` while `cs_n` is low. It produces a one-cycle `synth_wr_valid` pulse carrying the written byte. Strobes with `cs_n` high have no effect.
- R4: After an accepted data write, later data writes are dropped for WR_GAP_US microseconds, which is (CLK_HZ/1e6)*WR_GAP_US cycles. Status bit 6 reads 1 during that window and 0 after it.
- R5: A command write (`addr`=1) of 0x3F selects pass-through and queues the byte 0xFE into the holding register.
- R6: A command write of 0xFF selects synthesizer routing, empties the holding register, clears `rx_overrun`, and then queues 0xFE.
- R7: Command values other than 0x3F and 0xFF change nothing.
- R8: The receiver uses CLK_HZ/BAUD_HZ cycles per bit (BAUD_HZ defaults to 31250) and samples each bit at its middle. A frame whose stop bit is 0 is discarded, and the receiver waits for the line to go high again before it looks for a new start bit.
- R9: With synthesizer routing, each received byte gives a one-cycle `synth_rx_valid` pulse carrying the byte. The holding register and `irq` are left alone.
- R10: In pass-through, each received byte is loaded into the holding register, `irq` rises, and no `synth_rx_valid` pulse is produced.
- R11: `irq` stays high while a byte is held. It falls only after the rising edge of `rd_n` on a data read. A status read does not clear it.
- R12: A byte that arrives while the holding register is full is dropped, and `rx_overrun` is set. It stays set until a 0xFF command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Bus chip select, active low |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| addr | input | 1 | Register select: 0 data, 1 status/command |
| host_din | input | 8 | Write data from the bus |
| host_dout | output | 8 | Read data to the bus (combinational from `addr`) |
| irq | output | 1 | High while a byte waits for the host |
| midi_rx | input | 1 | Serial MIDI input line, idle high |
| synth_wr_valid | output | 1 | Pulse: host data byte for the synthesizer |
| synth_wr_byte | output | 8 | Host data byte |
| synth_rx_valid | output | 1 | Pulse: serial byte routed to the synthesizer |
| synth_rx_byte | output | 8 | Serial byte |
| passthru | output | 1 | High when serial bytes go to the host |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
The bench sends a serial byte while the holding register is still full. A design without the drop rule would overwrite the first byte, or would fail to set the sticky flag. It queues a received byte and then issues the 0xFF command. A design that does not flush first would give back the stale byte instead of 0xFE. It sends two data writes back to back, so a design without write spacing would let both reach the synthesizer. It also checks that a status read leaves the interrupt set, that a frame with a bad stop bit is discarded, and that strobes with chip select high and unknown commands change nothing.

// File: rtl/midi_hp_pkg.sv
// Shared constants and types for the MIDI host bus port.
package midi_hp_pkg;
    localparam logic [7:0] CMD_RESET    = 8'hFF;
    localparam logic [7:0] CMD_PASSTHRU = 8'h3F;
    localparam logic [7:0] ACK_BYTE     = 8'hFE;

    // One synchronized sample of the host bus.
    typedef struct packed {
        logic       cs_n;
        logic       rd_n;
        logic       wr_n;
        logic       addr;
        logic [7:0] data;
    } bus_sample_t;

    localparam int          BUS_W    = 12;
    localparam logic [11:0] BUS_IDLE = 12'hE00;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_RECOVER
    } rx_state_t;
endpackage

// File: rtl/midi_hp_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes each bit is a level that can be sampled on its own; no bus coherency is implied.
module midi_hp_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta;
        // Two-stage capture of bit i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= RST_VAL[i];
                q[i] <= RST_VAL[i];
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/midi_hp_bus_if.sv
// Host bus front end: synchronizes the strobes, select bit and data as one sample,
// and reports a write or data-read completion when a strobe rises.
// Assumes the host holds addr and data steady while its strobe is low.
module midi_hp_bus_if (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       addr,
    input  logic [7:0] din,
    output logic       wr_fire,
    output logic       rd_fire,
    output logic       wr_addr,
    output logic [7:0] wr_data
);
    import midi_hp_pkg::*;

    logic [BUS_W-1:0] raw_v;
    logic [BUS_W-1:0] cur_v;
    bus_sample_t      cur;
    bus_sample_t      prv;

    assign raw_v = {cs_n, rd_n, wr_n, addr, din};

    midi_hp_sync #(.WIDTH(BUS_W), .RST_VAL(BUS_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (cur_v)
    );

    assign cur = bus_sample_t'(cur_v);

    // Keep the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prv <= bus_sample_t'(BUS_IDLE);
        else        prv <= cur;
    end

    assign wr_fire = !prv.wr_n && cur.wr_n && !prv.cs_n;
    assign rd_fire = !prv.rd_n && cur.rd_n && !prv.cs_n && !prv.addr;
    assign wr_addr = prv.addr;
    assign wr_data = prv.data;
endmodule

// File: rtl/midi_hp_uart_rx.sv
// Serial MIDI receiver: 8 data bits, no parity, 1 stop bit, LSB first, mid-bit sampling.
// Assumes CLKS_PER_BIT >= 4. A bad stop bit drops the frame and waits for an idle line.
module midi_hp_uart_rx #(
    parameter int CLKS_PER_BIT = 1600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx,
    output logic       valid,
    output logic [7:0] byte_o
);
    import midi_hp_pkg::*;

    localparam int CNT_W = $clog2(CLKS_PER_BIT + 1);
    localparam int HALF  = CLKS_PER_BIT / 2;

    logic             rx_s;
    rx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       shreg;

    midi_hp_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_rx_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx),
        .q     (rx_s)
    );

    // Frame state machine with bit timing counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            valid   <= 1'b0;
            byte_o  <= '0;
        end else begin
            valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!rx_s) state <= RX_START;
                end
                RX_START: begin
                    if (cnt == CNT_W'(HALF - 1)) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
                        cnt   <= '0;
                        shreg <= {rx_s, shreg[7:1]};
                        if (bit_idx == 3'd7) state <= RX_STOP;
                        bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
                        cnt <= '0;
                        if (rx_s) begin
                            valid  <= 1'b1;
                            byte_o <= shreg;
                            state  <= RX_IDLE;
                        end else begin
                            state <= RX_RECOVER;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_RECOVER: begin
                    if (rx_s) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/midi_host_port.sv
// MIDI host bus port top. Decodes host writes into data and command transfers,
// routes serial bytes to the synthesizer or to a one-byte holding register,
// and drives the host interrupt and status.
// Assumes clk is at least several times faster than the host strobe pulses.
module midi_host_port #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int BAUD_HZ   = 31_250,
    parameter int WR_GAP_US = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       addr,
    input  logic [7:0] host_din,
    output logic [7:0] host_dout,
    output logic       irq,
    input  logic       midi_rx,
    output logic       synth_wr_valid,
    output logic [7:0] synth_wr_byte,
    output logic       synth_rx_valid,
    output logic [7:0] synth_rx_byte,
    output logic       passthru,
    output logic       rx_overrun
);
    import midi_hp_pkg::*;

    localparam int CLKS_PER_BIT = CLK_HZ / BAUD_HZ;
    localparam int GAP_CYC      = (CLK_HZ / 1_000_000) * WR_GAP_US;
    localparam int GAP_W        = $clog2(GAP_CYC + 1);

    logic             wr_fire;
    logic             rd_fire;
    logic             wr_addr;
    logic [7:0]       wr_data;
    logic             ser_valid;
    logic [7:0]       ser_byte;
    logic [GAP_W-1:0] gap_cnt;
    logic             busy;
    logic             ctl_fire;
    logic             data_fire;
    logic             is_reset_cmd;
    logic             is_pt_cmd;
    logic             rx_full;
    logic [7:0]       rx_byte;
    logic             full_n;
    logic [7:0]       byte_n;
    logic             drop;

    midi_hp_bus_if u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .din     (host_din),
        .wr_fire (wr_fire),
        .rd_fire (rd_fire),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    midi_hp_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx     (midi_rx),
        .valid  (ser_valid),
        .byte_o (ser_byte)
    );

    assign ctl_fire     = wr_fire && wr_addr;
    assign data_fire    = wr_fire && !wr_addr;
    assign is_reset_cmd = ctl_fire && (wr_data == CMD_RESET);
    assign is_pt_cmd    = ctl_fire && (wr_data == CMD_PASSTHRU);
    assign busy         = (gap_cnt != '0);

    // Write spacing timer, armed by each accepted data write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  gap_cnt <= '0;
        else if (data_fire && !busy) gap_cnt <= GAP_W'(GAP_CYC);
        else if (busy)               gap_cnt <= gap_cnt - 1'b1;
    end

    // Host data bytes forwarded to the synthesizer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synth_wr_valid <= 1'b0;
            synth_wr_byte  <= '0;
        end else begin
            synth_wr_valid <= data_fire && !busy;
            if (data_fire && !busy) synth_wr_byte <= wr_data;
        end
    end

    // Routing mode set by port commands.
    always_ff @(posedge clk) begin
        if (!rst_n)            passthru <= 1'b0;
        else if (is_reset_cmd) passthru <= 1'b0;
        else if (is_pt_cmd)    passthru <= 1'b1;
    end

    // Serial bytes forwarded to the synthesizer while not in pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synth_rx_valid <= 1'b0;
            synth_rx_byte  <= '0;
        end else begin
            synth_rx_valid <= ser_valid && !passthru;
            if (ser_valid && !passthru) synth_rx_byte <= ser_byte;
        end
    end

    // Next holding-register contents: read or flush first, then acknowledge, then serial.
    always_comb begin
        full_n = is_reset_cmd ? 1'b0 : (rx_full && !rd_fire);
        byte_n = rx_byte;
        drop   = 1'b0;
        if (is_reset_cmd || is_pt_cmd) begin
            if (!full_n) begin
                full_n = 1'b1;
                byte_n = ACK_BYTE;
            end else begin
                drop = 1'b1;
            end
            if (ser_valid && passthru) drop = 1'b1;
        end else if (ser_valid && passthru) begin
            if (!full_n) begin
                full_n = 1'b1;
                byte_n = ser_byte;
            end else begin
                drop = 1'b1;
            end
        end
    end

    // Holding register, interrupt and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full    <= 1'b0;
            rx_byte    <= '0;
            rx_overrun <= 1'b0;
        end else begin
            rx_full    <= full_n;
            rx_byte    <= byte_n;
            rx_overrun <= (is_reset_cmd ? 1'b0 : rx_overrun) | drop;
        end
    end

    assign irq       = rx_full;
    assign host_dout = addr ? {~rx_full, busy, 6'b111111} : rx_byte;
endmodule

// File: rtl/midi_hp_checker.sv
// Property checker for the MIDI host bus port, bound to the top module.
// Assumes the bind passes the top's clock and timing parameters.
module midi_hp_checker #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int WR_GAP_US = 3
) (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic passthru,
    input logic rx_overrun,
    input logic synth_wr_valid,
    input logic synth_rx_valid,
    input logic rd_fire,
    input logic ser_valid,
    input logic ctl_fire
);
    localparam int GAP_CYC = (CLK_HZ / 1_000_000) * WR_GAP_US;

    logic [31:0] since;

    // Cycles since the last host data pulse, saturating at the gap length.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since <= 32'(GAP_CYC);
        else if (synth_wr_valid)    since <= 32'd0;
        else if (since < GAP_CYC)   since <= since + 32'd1;
    end

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq && !passthru && !rx_overrun));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        synth_wr_valid |=> !synth_wr_valid);

    a_r4_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
        synth_wr_valid |-> (since >= GAP_CYC));

    a_r9_synth_route: assert property (@(posedge clk) disable iff (!rst_n)
        synth_rx_valid |-> $past(!passthru));

    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ser_valid) || $past(ctl_fire)));

    a_r11_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_fire));

    a_r12_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> (rx_overrun || irq));
endmodule

bind midi_host_port midi_hp_checker #(
    .CLK_HZ    (CLK_HZ),
    .WR_GAP_US (WR_GAP_US)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .irq            (irq),
    .passthru       (passthru),
    .rx_overrun     (rx_overrun),
    .synth_wr_valid (synth_wr_valid),
    .synth_rx_valid (synth_rx_valid),
    .rd_fire        (rd_fire),
    .ser_valid      (ser_valid),
    .ctl_fire       (ctl_fire)
);

// File: tb/midi_host_port_bench.sv
// Self-checking bench for the MIDI host bus port.
module midi_host_port_bench;
    localparam int CLK_HZ    = 50_000_000;
    localparam int BAUD_HZ   = 500_000;
    localparam int WR_GAP_US = 3;
    localparam int BIT_CYC   = CLK_HZ / BAUD_HZ;
    localparam int GAP_CYC   = (CLK_HZ / 1_000_000) * WR_GAP_US;

    // Each entry: {data byte written, byte expected at synth_wr_byte}.
    localparam int NVEC = 5;
    localparam logic [15:0] WVEC [NVEC] = '{16'h9090, 16'h3C3C, 16'h0000, 16'hFFFF, 16'h7F7F};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       addr = 1'b0;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout;
    logic       irq;
    logic       midi_rx = 1'b1;
    logic       synth_wr_valid;
    logic [7:0] synth_wr_byte;
    logic       synth_rx_valid;
    logic [7:0] synth_rx_byte;
    logic       passthru;
    logic       rx_overrun;

    int checks = 0;
    int failures = 0;
    int wr_count = 0;
    int rx_count = 0;
    logic [7:0] wr_last = 8'h00;
    logic [7:0] rx_last = 8'h00;
    logic done = 1'b0;

    always #10 clk = ~clk;

    midi_host_port #(
        .CLK_HZ    (CLK_HZ),
        .BAUD_HZ   (BAUD_HZ),
        .WR_GAP_US (WR_GAP_US)
    ) u_midi_host_port (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_n           (cs_n),
        .rd_n           (rd_n),
        .wr_n           (wr_n),
        .addr           (addr),
        .host_din       (host_din),
        .host_dout      (host_dout),
        .irq            (irq),
        .midi_rx        (midi_rx),
        .synth_wr_valid (synth_wr_valid),
        .synth_wr_byte  (synth_wr_byte),
        .synth_rx_valid (synth_rx_valid),
        .synth_rx_byte  (synth_rx_byte),
        .passthru       (passthru),
        .rx_overrun     (rx_overrun)
    );

    // Record the synthesizer-side pulses.
    always @(posedge clk) begin
        if (synth_wr_valid) begin
            wr_count <= wr_count + 1;
            wr_last  <= synth_wr_byte;
        end
        if (synth_rx_valid) begin
            rx_count <= rx_count + 1;
            rx_last  <= synth_rx_byte;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        addr = a; host_din = d; cs_n = sel_n;
        repeat (2) @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a; cs_n = 1'b0;
        repeat (2) @(negedge clk);
        rd_n = 1'b0;
        repeat (2) @(negedge clk);
        d = host_dout;
        rd_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_serial(input logic [7:0] b, input logic stop_bit);
        @(negedge clk);
        midi_rx = 1'b0;
        repeat (BIT_CYC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            midi_rx = b[i];
            repeat (BIT_CYC) @(negedge clk);
        end
        midi_rx = stop_bit;
        repeat (BIT_CYC) @(negedge clk);
        midi_rx = 1'b1;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int base;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 passthru", passthru, 0);
        chk("R1 overrun", rx_overrun, 0);
        bus_read(1'b1, rd);
        chk("R1 status", rd, 8'hBF);

        // R3: vector table of data writes
        for (int v = 0; v < NVEC; v++) begin
            base = wr_count;
            bus_write(1'b0, WVEC[v][15:8], 1'b0);
            chk("R3 pulse count", wr_count - base, 1);
            chk("R3 byte", wr_last, WVEC[v][7:0]);
            repeat (GAP_CYC + 10) @(negedge clk);
        end

        // R3: strobe with chip select high is ignored
        base = wr_count;
        bus_write(1'b0, 8'h12, 1'b1);
        chk("R3 cs high ignored", wr_count - base, 0);

        // R4: write spacing
        base = wr_count;
        bus_write(1'b0, 8'hAA, 1'b0);
        bus_read(1'b1, rd);
        chk("R4 status busy", rd, 8'hFF);
        bus_write(1'b0, 8'h55, 1'b0);
        chk("R4 second dropped", wr_count - base, 1);
        chk("R4 kept first", wr_last, 8'hAA);
        repeat (GAP_CYC + 10) @(negedge clk);
        bus_read(1'b1, rd);
        chk("R4 status ready", rd, 8'hBF);

        // R8 R9: serial byte to synthesizer
        base = rx_count;
        send_serial(8'h93, 1'b1);
        chk("R9 synth rx count", rx_count - base, 1);
        chk("R8 synth rx byte", rx_last, 8'h93);
        chk("R9 irq untouched", irq, 0);

        // R8: bad stop bit discarded, then normal reception resumes
        base = rx_count;
        send_serial(8'h44, 1'b0);
        chk("R8 bad stop dropped", rx_count - base, 0);
        send_serial(8'h5A, 1'b1);
        chk("R8 recover count", rx_count - base, 1);
        chk("R8 recover byte", rx_last, 8'h5A);

        // R7: unknown command
        bus_write(1'b1, 8'h55, 1'b0);
        chk("R7 irq", irq, 0);
        chk("R7 passthru", passthru, 0);

        // R5: enter pass-through
        bus_write(1'b1, 8'h3F, 1'b0);
        chk("R5 passthru", passthru, 1);
        chk("R5 irq", irq, 1);
        bus_read(1'b1, rd);
        chk("R2 status full", rd, 8'h3F);
        chk("R11 status read keeps irq", irq, 1);
        bus_read(1'b0, rd);
        chk("R5 ack byte", rd, 8'hFE);
        chk("R11 irq cleared", irq, 0);

        // R10: serial byte to host
        base = rx_count;
        send_serial(8'h90, 1'b1);
        chk("R10 irq", irq, 1);
        chk("R10 no synth pulse", rx_count - base, 0);
        bus_read(1'b0, rd);
        chk("R10 data", rd, 8'h90);

        // R12: overrun
        send_serial(8'h11, 1'b1);
        send_serial(8'h22, 1'b1);
        chk("R12 overrun", rx_overrun, 1);
        bus_read(1'b0, rd);
        chk("R12 first kept", rd, 8'h11);
        chk("R12 irq cleared", irq, 0);
        chk("R12 sticky", rx_overrun, 1);

        // R6: reset command flushes pending byte and clears overrun
        send_serial(8'h33, 1'b1);
        bus_write(1'b1, 8'hFF, 1'b0);
        chk("R6 passthru", passthru, 0);
        chk("R6 overrun", rx_overrun, 0);
        chk("R6 irq", irq, 1);
        bus_read(1'b0, rd);
        chk("R6 ack not stale", rd, 8'hFE);
        base = rx_count;
        send_serial(8'h7C, 1'b1);
        chk("R6 synth routed", rx_count - base, 1);
        chk("R6 synth byte", rx_last, 8'h7C);
        chk("R6 irq idle", irq, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule